// File: doc/BRIEF.md
# Byte-Serial Target Port with Write-Collision Flag

This block is the receiving side of a four-wire synchronous serial link. The external bit clock, data-in line and active-low select line come from an outside controller. The block samples all three with a fast system clock through synchronizer chains, then finds bit-clock edges by comparing the synchronized level with its previous value. Bits move most significant first, eight per byte.

Two mode inputs set the bit-clock idle level and the sampling phase. Software places a byte to send in the data register and reads the received byte from the same address. A status word carries a byte-done flag and a write-collision flag. Reading registers clears each flag, as set out below. Software talks to the block over a small valid/ready request port. Every accepted read returns its data one cycle later.

In phase 0 every byte needs a new select falling edge. A data write while select is low is refused and raises the collision flag. In phase 1, select may stay low across several bytes.

Top module: `spi_target_port`

## Requirements
- R1: `mode_i[1]` is the bit-clock idle level and `mode_i[0]` is the phase. The leading edge is the edge that leaves the idle level. The trailing edge is the edge that returns to it. All four combinations transfer data correctly.
- R2: Data leaves on `miso_pin` and arrives on `mosi_pin` most significant bit first, eight bits per byte. A read of address 0 returns the last complete byte received.
- R3: In phase 0, `miso_pin` shows the top bit of the stored transmit byte once select is low, before any bit-clock edge. Input is sampled on leading edges and the output shifts on trailing edges.
- R4: In phase 1, the output changes on the leading edge and the input is sampled on the trailing edge. Select may stay low across consecutive bytes, and each new byte sends the transmit byte stored at that time.
- R5: In phase 0, after a byte completes, further bit-clock edges are ignored until select goes high and then low again.
- R6: In phase 0, a write to address 0 while select is low sets the collision flag and leaves the stored transmit byte unchanged. In phase 1 such a write is accepted and raises no collision.
- R7: The byte-done flag, status bit 7 (address 1), sets when the eighth bit of a byte has been sampled.
- R8: A read of address 0 clears byte-done, but only after a status read that returned byte-done set. The collision flag, status bit 6, clears on a status read that returned it set. All other status bits read 0.
- R9: If select goes high mid-byte, the partial byte is dropped and the bit count restarts. Byte-done stays clear and address 0 keeps its previous value.
- R10: `miso_oe` is low whenever select is high, and high while select is low.
- R11: `req_ready` is always high. Each read accepted with `req_valid` high and `req_write` low returns `rsp_valid` high with its data exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Bit 1 idle level, bit 0 phase |
| sck_pin | input | 1 | External bit clock |
| mosi_pin | input | 1 | Serial data in |
| ss_n_pin | input | 1 | Active-low select |
| miso_pin | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the data-out driver |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 1 | 0 data, 1 status |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The bench uses the default DATA_W of 8 and two synchronizer stages. It holds each bit-clock level for eight system cycles, so every pin change passes the synchronizers before the next one arrives. Random bytes run through all four modes. Because the bench can sample `miso_pin` between edges, it can tell leading-edge drive from trailing-edge drive. Directed cases cover a collision, several bytes under one select in phase 1, extra clocks after a phase-0 byte, and a byte aborted after four bits.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;
    // register address map (one address bit)
    typedef enum logic {
        ADDR_DATA = 1'b0,
        ADDR_STAT = 1'b1
    } reg_addr_e;

    // mode input layout: [1] idle level, [0] phase
    typedef struct packed {
        logic pol;
        logic pha;
    } spi_mode_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2   // must be at least 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_pin,
    input  logic mosi_pin,
    input  logic ss_n_pin,
    input  logic pol,
    output logic sck_lead,
    output logic sck_trail,
    output logic mosi_s,
    output logic ss_low,
    output logic ss_fall,
    output logic ss_rise
);
    typedef struct packed {
        logic [STAGES-1:0] sck;
        logic [STAGES-1:0] mosi;
        logic [STAGES-1:0] ssn;
        logic              sck_prev;
        logic              ssn_prev;
    } sync_st_t;

    sync_st_t sync_q, sync_d;

    always_comb begin
        sync_d          = sync_q;
        sync_d.sck      = {sync_q.sck[STAGES-2:0],  sck_pin};
        sync_d.mosi     = {sync_q.mosi[STAGES-2:0], mosi_pin};
        sync_d.ssn      = {sync_q.ssn[STAGES-2:0],  ss_n_pin};
        sync_d.sck_prev = sync_q.sck[STAGES-1];
        sync_d.ssn_prev = sync_q.ssn[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.sck      <= '0;
            sync_q.mosi     <= '0;
            sync_q.ssn      <= '1;
            sync_q.sck_prev <= 1'b0;
            sync_q.ssn_prev <= 1'b1;
        end else begin
            sync_q <= sync_d;
        end
    end

    logic sck_now, ssn_now;
    assign sck_now   = sync_q.sck[STAGES-1];
    assign ssn_now   = sync_q.ssn[STAGES-1];
    assign sck_lead  = (sync_q.sck_prev == pol) && (sck_now != pol);
    assign sck_trail = (sync_q.sck_prev != pol) && (sck_now == pol);
    assign mosi_s    = sync_q.mosi[STAGES-1];
    assign ss_low    = !ssn_now;
    assign ss_fall   = sync_q.ssn_prev && !ssn_now;
    assign ss_rise   = !sync_q.ssn_prev && ssn_now;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pha,
    input  logic              sck_lead,
    input  logic              sck_trail,
    input  logic              mosi_s,
    input  logic              ss_low,
    input  logic              ss_fall,
    input  logic              ss_rise,
    input  logic [DATA_W-1:0] tx_hold,
    output logic              miso_bit,
    output logic              miso_oe,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] tx_sr;
        logic [DATA_W-1:0] rx_sr;
        logic [DATA_W-1:0] rx_word;
        logic [CNT_W-1:0]  cnt;
        logic              armed;
        logic              oe;
        logic              done;
    } eng_st_t;

    eng_st_t eng_q, eng_d;
    logic sample_edge, drive_edge;
    logic [DATA_W-1:0] rx_next;

    always_comb begin
        eng_d       = eng_q;
        eng_d.done  = 1'b0;
        eng_d.oe    = ss_low;
        sample_edge = pha ? sck_trail : sck_lead;
        drive_edge  = pha ? sck_lead  : sck_trail;
        rx_next     = {eng_q.rx_sr[DATA_W-2:0], mosi_s};
        if (!ss_low) begin
            eng_d.cnt   = '0;
            eng_d.armed = 1'b0;
        end else if (ss_fall) begin
            eng_d.cnt   = '0;
            eng_d.armed = 1'b1;
            eng_d.tx_sr = tx_hold;
        end else if (eng_q.armed) begin
            if (drive_edge) begin
                if (pha && (eng_q.cnt == '0)) eng_d.tx_sr = tx_hold;
                else                          eng_d.tx_sr = eng_q.tx_sr << 1;
            end
            if (sample_edge) begin
                eng_d.rx_sr = rx_next;
                if (eng_q.cnt == LAST_BIT) begin
                    eng_d.done    = 1'b1;
                    eng_d.rx_word = rx_next;
                    eng_d.cnt     = '0;
                    if (!pha) eng_d.armed = 1'b0;
                end else begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign miso_bit  = eng_q.tx_sr[DATA_W-1];
    assign miso_oe   = eng_q.oe;
    assign byte_done = eng_q.done;
    assign rx_byte   = eng_q.rx_word;

    // R9
    abort_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_rise |=> (eng_q.cnt == '0) && !eng_q.done);

    // R5
    rearm_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pha && !eng_q.armed && !ss_fall) |=> !eng_q.done);

    // R10
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_low |=> !eng_q.oe);
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              pha,
    input  logic              ss_low,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [DATA_W-1:0] tx_hold
);
    localparam int DONE_BIT = DATA_W - 1;
    localparam int COLL_BIT = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] tx_hold;
        logic [DATA_W-1:0] rx_hold;
        logic [DATA_W-1:0] rsp_data;
        logic              rsp_valid;
        logic              done;
        logic              done_seen;
        logic              coll;
    } rf_st_t;

    rf_st_t rf_q, rf_d;
    logic wr_data, rd_data, rd_stat;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        rf_d      = rf_q;
        wr_data   = req_valid &&  req_write && (req_addr == ADDR_DATA);
        rd_data   = req_valid && !req_write && (req_addr == ADDR_DATA);
        rd_stat   = req_valid && !req_write && (req_addr == ADDR_STAT);
        stat_word = '0;
        stat_word[DONE_BIT] = rf_q.done;
        stat_word[COLL_BIT] = rf_q.coll;

        rf_d.rsp_valid = req_valid && !req_write;
        if (rd_data) rf_d.rsp_data = rf_q.rx_hold;
        if (rd_stat) rf_d.rsp_data = stat_word;

        if (wr_data) begin
            if (!pha && ss_low) rf_d.coll    = 1'b1;
            else                rf_d.tx_hold = req_wdata;
        end
        if (rd_stat) begin
            if (rf_q.done) rf_d.done_seen = 1'b1;
            if (rf_q.coll) rf_d.coll      = 1'b0;
        end
        if (rd_data && rf_q.done_seen) begin
            rf_d.done      = 1'b0;
            rf_d.done_seen = 1'b0;
        end
        if (byte_done) begin
            rf_d.done      = 1'b1;
            rf_d.done_seen = 1'b0;
            rf_d.rx_hold   = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= '0;
        else        rf_q <= rf_d;
    end

    assign req_ready = 1'b1;
    assign rsp_valid = rf_q.rsp_valid;
    assign rsp_rdata = rf_q.rsp_data;
    assign tx_hold   = rf_q.tx_hold;

    // R6
    collision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !pha && ss_low) |=> rf_q.coll && (rf_q.tx_hold == $past(rf_q.tx_hold)));

    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> rf_q.done && (rf_q.rx_hold == $past(rx_byte)));

    // R11
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);
endmodule

// File: rtl/spi_target_port.sv
module spi_target_port
    import spi_tgt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              sck_pin,
    input  logic              mosi_pin,
    input  logic              ss_n_pin,
    output logic              miso_pin,
    output logic              miso_oe,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    spi_mode_t mode;
    assign mode = spi_mode_t'(mode_i);

    logic sck_lead, sck_trail, mosi_s, ss_low, ss_fall, ss_rise;
    logic byte_done;
    logic [DATA_W-1:0] rx_byte, tx_hold;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .sck_pin(sck_pin), .mosi_pin(mosi_pin), .ss_n_pin(ss_n_pin), .pol(mode.pol),
        .sck_lead(sck_lead), .sck_trail(sck_trail), .mosi_s(mosi_s),
        .ss_low(ss_low), .ss_fall(ss_fall), .ss_rise(ss_rise)
    );

    spi_shift_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .pha(mode.pha),
        .sck_lead(sck_lead), .sck_trail(sck_trail), .mosi_s(mosi_s),
        .ss_low(ss_low), .ss_fall(ss_fall), .ss_rise(ss_rise),
        .tx_hold(tx_hold), .miso_bit(miso_pin), .miso_oe(miso_oe),
        .byte_done(byte_done), .rx_byte(rx_byte)
    );

    spi_reg_file #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .pha(mode.pha), .ss_low(ss_low),
        .byte_done(byte_done), .rx_byte(rx_byte),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .tx_hold(tx_hold)
    );
endmodule

// File: tb/sim_spi_target_port.sv
module sim_spi_target_port;
    localparam int H = 8;   // system cycles per bit-clock level

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode_i = 2'b00;
    logic sck_pin = 1'b0, mosi_pin = 1'b0, ss_n_pin = 1'b1;
    logic miso_pin, miso_oe;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_addr = 1'b0;
    logic [7:0] req_wdata = '0;
    logic rsp_valid;
    logic [7:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int seed_val;

    always #2 clk = ~clk;

    spi_target_port u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .sck_pin(sck_pin), .mosi_pin(mosi_pin), .ss_n_pin(ss_n_pin),
        .miso_pin(miso_pin), .miso_oe(miso_oe),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [7:0] stat_exp(input logic done, input logic coll);
        return {done, coll, 6'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic a, input logic [7:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic reg_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 rsp_valid", rsp_valid, 1'b1);
        v = rsp_rdata;
    endtask

    task automatic sel(input logic lvl);
        ss_n_pin = lvl;
        wait_cyc(H);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_i = m;
        sck_pin = m[1];
        wait_cyc(H);
    endtask

    task automatic shift_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
        mi = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (!mode_i[0]) begin
                mosi_pin = mo[i];
                wait_cyc(H);
                mi[i] = miso_pin;
                sck_pin = ~mode_i[1];
                wait_cyc(H);
                sck_pin = mode_i[1];
            end else begin
                sck_pin = ~mode_i[1];
                mosi_pin = mo[i];
                wait_cyc(H);
                mi[i] = miso_pin;
                sck_pin = mode_i[1];
                wait_cyc(H);
            end
        end
        wait_cyc(H);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] rd, mi, tx, mo, prev_rx;
        seed_val = $urandom(32'h5eed);
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);

        // reset state
        chk("R10 oe at reset", miso_oe, 1'b0);
        chk("R11 ready", req_ready, 1'b1);
        reg_read(1'b1, rd);
        chk("R7 status at reset", rd, stat_exp(1'b0, 1'b0));

        // random bytes, all four modes
        for (int r = 0; r < 3; r++) begin
            for (int m = 0; m < 4; m++) begin
                set_mode(2'(m));
                tx = 8'($urandom); mo = 8'($urandom);
                reg_write(1'b0, tx);
                sel(1'b0);
                chk("R10 oe when selected", miso_oe, 1'b1);
                if (m[0] == 1'b0) chk("R3 msb before first edge", miso_pin, tx[7]);
                shift_bits(mo, 8, mi);
                sel(1'b1);
                chk("R10 oe after deselect", miso_oe, 1'b0);
                chk(m[0] ? "R4 R1 sent byte" : "R3 R1 sent byte", mi, tx);
                reg_read(1'b1, rd);
                chk("R7 done set", rd, stat_exp(1'b1, 1'b0));
                reg_read(1'b0, rd);
                chk("R2 received byte", rd, mo);
                reg_read(1'b1, rd);
                chk("R8 done cleared", rd, stat_exp(1'b0, 1'b0));
            end
        end

        // R6 collision in phase 0
        set_mode(2'b00);
        reg_write(1'b0, 8'hA5);
        sel(1'b0);
        reg_write(1'b0, 8'h3C);
        reg_read(1'b1, rd);
        chk("R6 collision flag", rd, stat_exp(1'b0, 1'b1));
        shift_bits(8'h96, 8, mi);
        chk("R6 tx unchanged", mi, 8'hA5);
        sel(1'b1);
        reg_read(1'b1, rd);
        chk("R8 status after collision byte", rd, stat_exp(1'b1, 1'b0));
        reg_read(1'b0, rd);
        chk("R2 rx after collision", rd, 8'h96);
        reg_read(1'b1, rd);
        chk("R8 both flags clear", rd, stat_exp(1'b0, 1'b0));

        // R8: data read without prior status read leaves done set
        sel(1'b0);
        shift_bits(8'h11, 8, mi);
        sel(1'b1);
        reg_read(1'b0, rd);
        reg_read(1'b1, rd);
        chk("R8 done kept without status read", rd, stat_exp(1'b1, 1'b0));
        reg_read(1'b0, rd);
        reg_read(1'b1, rd);
        chk("R8 done cleared after status then data", rd, stat_exp(1'b0, 1'b0));

        // R4 phase 1: several bytes under one select, writes accepted
        set_mode(2'b01);
        reg_write(1'b0, 8'h5A);
        sel(1'b0);
        shift_bits(8'hC3, 8, mi);
        chk("R4 first byte out", mi, 8'h5A);
        reg_write(1'b0, 8'hE7);
        reg_read(1'b1, rd);
        chk("R6 no collision in phase 1", rd, stat_exp(1'b1, 1'b0));
        reg_read(1'b0, rd);
        chk("R4 first byte in", rd, 8'hC3);
        shift_bits(8'h24, 8, mi);
        chk("R4 second byte out", mi, 8'hE7);
        reg_read(1'b1, rd);
        chk("R4 second done", rd, stat_exp(1'b1, 1'b0));
        reg_read(1'b0, rd);
        chk("R4 second byte in", rd, 8'h24);
        sel(1'b1);

        // R5 phase 0: no second byte without reselect
        set_mode(2'b10);
        sel(1'b0);
        shift_bits(8'h81, 8, mi);
        reg_read(1'b1, rd);
        reg_read(1'b0, rd);
        chk("R5 first byte", rd, 8'h81);
        shift_bits(8'h7E, 8, mi);
        reg_read(1'b1, rd);
        chk("R5 no done without reselect", rd, stat_exp(1'b0, 1'b0));
        reg_read(1'b0, rd);
        chk("R5 rx unchanged", rd, 8'h81);
        sel(1'b1);

        // R9 abort mid-byte
        prev_rx = 8'h81;
        sel(1'b0);
        shift_bits(8'hF0, 4, mi);
        sel(1'b1);
        reg_read(1'b1, rd);
        chk("R9 done clear after abort", rd, stat_exp(1'b0, 1'b0));
        reg_read(1'b0, rd);
        chk("R9 rx kept after abort", rd, prev_rx);
        sel(1'b0);
        shift_bits(8'h4B, 8, mi);
        sel(1'b1);
        reg_read(1'b1, rd);
        chk("R9 full byte after abort", rd, stat_exp(1'b1, 1'b0));
        reg_read(1'b0, rd);
        chk("R9 count restarted", rd, 8'h4B);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule